// File: doc/BRIEF.md
# Safeload Parameter Update Buffer

This block stages a small set of coefficient writes for a 1024-word, 28-bit parameter memory and then applies the whole set in a single burst. A host fills up to five slots. Each slot holds a 10-bit target address and a 28-bit two's-complement value in 5.23 fixed point. The host then raises a commit request. The buffer waits for the next frame boundary reported by the processing core. It then copies every occupied slot into the parameter memory, and it writes only in cycles where the core reports that it is not touching that memory. A complete filter section therefore changes between two audio samples, and the core never sees half of an update.

Host slot writes use a valid/ready handshake. A slot write transfers on a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` is low for the whole time the buffer is busy, so the host has to hold or drop the write while a commit is in progress. The memory-side port follows the same rule. `pw_en` acts as valid and `core_ram_free` acts as ready, and a word is written only in a cycle where both are high. The core can stall the copy at any time by lowering `core_ram_free`. The address port is only 10 bits wide, so nothing other than the parameter memory can be reached through this path.

Top module: `safeload_buffer`

## Requirements
- R1: After reset, `busy` is 0, `ld_ready` is 1, `pw_en` is 0 and no slot is occupied. A commit issued right after reset writes nothing.
- R2: A slot write is taken when `ld_valid` and `ld_ready` are both high. It marks the slot given by `ld_slot` (0 to 4) as occupied. A write to a slot index of 5 or above is taken but changes nothing.
- R3: A commit request that sees at least one occupied slot raises `busy` in the next cycle. `busy` then stays high until the clock edge that completes the last memory write, and it falls at that edge.
- R4: No memory write happens until a `frame_tick` pulse arrives after the commit. The earliest write is in the cycle that follows that pulse.
- R5: `pw_en` is high only in cycles where `core_ram_free` is high. A cycle with `core_ram_free` low stalls the copy without losing any entry.
- R6: Exactly one write is made per occupied slot, in ascending slot order, carrying that slot's stored address and data.
- R7: When a commit finishes, every slot is empty, so a further commit writes nothing and leaves `busy` low.
- R8: A commit request with no occupied slots leaves `busy` low and produces no memory write.
- R9: While `busy` is high, `ld_ready` is 0 and offered slot writes leave the slots unchanged.
- R10: A slot write and a commit request in the same cycle are both taken, and the entry just written is part of that commit.
- R11: Writing a slot again before the commit replaces its contents. Only the last value is written to memory.
- R12: A commit request made while `busy` is high has no effect on the commit in progress or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Host offers a slot write |
| ld_ready | output | 1 | Buffer can take a slot write (low while busy) |
| ld_slot | input | 3 | Slot index, 0 to 4 |
| ld_addr | input | 10 | Parameter memory target address |
| ld_data | input | 28 | Coefficient value, 5.23 two's complement |
| commit_req | input | 1 | One-cycle request to apply the staged set |
| busy | output | 1 | Commit pending or copying |
| frame_tick | input | 1 | One-cycle pulse at an audio frame boundary |
| core_ram_free | input | 1 | Core is not accessing the parameter memory this cycle |
| pw_en | output | 1 | Parameter memory write strobe |
| pw_addr | output | 10 | Parameter memory write address |
| pw_data | output | 28 | Parameter memory write data |

## Verification
Two functions can fall in the same cycle. The first is a host slot write together with a commit request (R10). The bench drives `ld_valid` and `commit_req` on the same edge and then checks that the entry just written appears as a memory write after the next frame pulse. The second is the core taking the memory back in the middle of a copy (R5). Rows of the vector table give irregular `core_ram_free` patterns. The bench checks that every strobe falls in a free cycle, that the writes stay in ascending slot order, and that `busy` falls on exactly the edge of the last write.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int SL_SLOTS  = 5;
  localparam int SL_ADDR_W = 10;
  localparam int SL_DATA_W = 28;

  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_ARMED = 2'd1,
    SL_COPY  = 2'd2
  } sl_state_e;
endpackage

// File: rtl/sl_slot_bank.sv
module sl_slot_bank #(
  parameter int SLOTS  = 5,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 28,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SLOTS-1:0]  occ_o,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_w, hit_c;
    assign hit_w = wr_en && (wr_idx == IDX_W'(g));
    assign hit_c = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_o[g]  <= 1'b0;
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else begin
        if (hit_w) begin
          occ_o[g]  <= 1'b1;
          addr_q[g] <= wr_addr;
          data_q[g] <= wr_data;
        end else if (hit_c) begin
          occ_o[g] <= 1'b0;
        end
      end
    end

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(addr_q[g]) && $stable(data_q[g]))); // R9
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_addr = addr_q[i];
        rd_data = data_q[i];
      end
    end
  end
endmodule

// File: rtl/sl_pick_lowest.sv
module sl_pick_lowest #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3
) (
  input  logic [SLOTS-1:0] occ,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (occ[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sl_ctrl.sv
module sl_ctrl
  import sl_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic             frame_tick,
  input  logic             core_ram_free,
  input  logic             work_next,
  input  logic [SLOTS-1:0] occ,
  input  logic             found,
  input  logic [IDX_W-1:0] pick_idx,
  output logic             busy,
  output logic             copy_we
);
  sl_state_e        state_q;
  logic             single;
  logic             have_prev_q;
  logic [IDX_W-1:0] prev_idx_q;

  assign single  = found && ((occ & (occ - 1'b1)) == '0);
  assign copy_we = (state_q == SL_COPY) && core_ram_free && found;
  assign busy    = (state_q != SL_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
    end else begin
      unique case (state_q)
        SL_IDLE:  if (commit_req && work_next) state_q <= SL_ARMED;
        SL_ARMED: if (frame_tick) state_q <= SL_COPY;
        SL_COPY:  if (copy_we && single) state_q <= SL_IDLE;
        default:  state_q <= SL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_idx_q  <= '0;
    end else if (state_q == SL_ARMED) begin
      have_prev_q <= 1'b0;
    end else if (copy_we) begin
      have_prev_q <= 1'b1;
      prev_idx_q  <= pick_idx;
    end
  end

  AST_ASCENDING_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_we && have_prev_q) |-> (pick_idx > prev_idx_q)); // R6
  AST_ARMED_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_ARMED) |-> (occ != '0)); // R8
  AST_COPY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_ARMED) && !frame_tick |=> (state_q != SL_COPY)); // R4
endmodule

// File: rtl/safeload_buffer.sv
module safeload_buffer
  import sl_pkg::*;
#(
  parameter int SLOTS  = SL_SLOTS,
  parameter int ADDR_W = SL_ADDR_W,
  parameter int DATA_W = SL_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  output logic                     ld_ready,
  input  logic [$clog2(SLOTS)-1:0] ld_slot,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  input  logic                     commit_req,
  output logic                     busy,
  input  logic                     frame_tick,
  input  logic                     core_ram_free,
  output logic                     pw_en,
  output logic [ADDR_W-1:0]        pw_addr,
  output logic [DATA_W-1:0]        pw_data
);
  localparam int IDX_W = $clog2(SLOTS);

  logic             take;
  logic             slot_wr;
  logic [SLOTS-1:0] occ;
  logic             found;
  logic [IDX_W-1:0] pick_idx;
  logic             copy_we;
  logic             work_next;

  assign ld_ready  = !busy;
  assign take      = ld_valid && ld_ready;
  assign slot_wr   = take && (int'(ld_slot) < SLOTS);
  assign work_next = (occ != '0) || slot_wr;
  assign pw_en     = copy_we;

  sl_slot_bank #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy),
    .wr_en   (slot_wr),
    .wr_idx  (ld_slot),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .clr_en  (copy_we),
    .clr_idx (pick_idx),
    .rd_idx  (pick_idx),
    .occ_o   (occ),
    .rd_addr (pw_addr),
    .rd_data (pw_data)
  );

  sl_pick_lowest #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pick (
    .occ   (occ),
    .found (found),
    .idx   (pick_idx)
  );

  sl_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_req    (commit_req),
    .frame_tick    (frame_tick),
    .core_ram_free (core_ram_free),
    .work_next     (work_next),
    .occ           (occ),
    .found         (found),
    .pick_idx      (pick_idx),
    .busy          (busy),
    .copy_we       (copy_we)
  );

  AST_WRITE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pw_en |-> (core_ram_free && busy)); // R5
  AST_EMPTY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (occ == '0)); // R7
  AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(occ) || $past(pw_en)); // R9
endmodule

// File: tb/safeload_buffer_tb_top.sv
`timescale 1ns/1ps
module safeload_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [2:0]  ld_slot = '0;
  logic [9:0]  ld_addr = '0;
  logic [27:0] ld_data = '0;
  logic        commit_req = 1'b0;
  logic        busy;
  logic        frame_tick = 1'b0;
  logic        core_ram_free = 1'b0;
  logic        pw_en;
  logic [9:0]  pw_addr;
  logic [27:0] pw_data;

  int total = 0;
  int bad = 0;
  bit in_copy = 1'b0;
  logic [9:0]  ea [5];
  logic [27:0] ed [5];

  always #10 clk = ~clk;

  safeload_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_slot(ld_slot), .ld_addr(ld_addr), .ld_data(ld_data),
    .commit_req(commit_req), .busy(busy), .frame_tick(frame_tick),
    .core_ram_free(core_ram_free), .pw_en(pw_en), .pw_addr(pw_addr),
    .pw_data(pw_data)
  );

  // rows: {slot mask[12:8], core-free pattern[7:0]}
  localparam logic [12:0] ROWS [6] = '{
    {5'b11111, 8'hFF},
    {5'b10101, 8'b10110101},
    {5'b00001, 8'b00000100},
    {5'b01010, 8'b01010101},
    {5'b10000, 8'b11000000},
    {5'b00000, 8'hFF}
  };

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mk_addr(int r, int s);
    return 10'((r * 149 + s * 67 + 5) % 1024);
  endfunction

  function automatic logic [27:0] mk_data(int r, int s);
    return 28'(((r + 1) * 32'h0123457) ^ (s * 32'h1F00F01));
  endfunction

  task automatic put(int s, logic [9:0] a, logic [27:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_slot = 3'(s); ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    in_copy = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic run_copy(int n, logic [7:0] pat);
    int got = 0;
    for (int c = 0; c < 64; c++) begin
      if (c > 0) @(negedge clk);
      core_ram_free = pat[c % 8];
      #1;
      if (!busy) break;
      if (got == n && n > 0) chk(1'b0, "R3 busy after last write", busy, 0);
      if (pw_en) begin
        chk(core_ram_free, "R5 write while core busy", core_ram_free, 1);
        if (got < n) begin
          chk(pw_addr == ea[got], "R6 address order", pw_addr, ea[got]);
          chk(pw_data == ed[got], "R6 data", pw_data, ed[got]);
        end
        got++;
      end
    end
    chk(got == n, "R6 write count", got, n);
    @(negedge clk);
    core_ram_free = 1'b0;
    in_copy = 1'b0;
  endtask

  always @(negedge clk) begin
    #2;
    if (pw_en && !in_copy) chk(1'b0, "R4 write outside copy window", pw_en, 0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(ld_ready == 1, "R1 ready after reset", ld_ready, 1);
    chk(pw_en == 0, "R1 no write after reset", pw_en, 0);
    commit();
    chk(busy == 0, "R1 commit with nothing staged", busy, 0);

    // R2: out-of-range slot indices have no effect
    put(5, 10'h3FF, 28'h1);
    put(7, 10'h3FE, 28'h2);
    commit();
    chk(busy == 0, "R2 out-of-range slot ignored", busy, 0);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int r = 0; r < 6; r++) begin
      logic [4:0] m;
      int n;
      m = ROWS[r][12:8];
      n = 0;
      for (int s = 0; s < 5; s++) begin
        if (m[s]) begin
          put(s, mk_addr(r, s), mk_data(r, s));
          ea[n] = mk_addr(r, s);
          ed[n] = mk_data(r, s);
          n++;
        end
      end
      commit();
      if (n == 0) begin
        chk(busy == 0, "R8 empty commit stays idle", busy, 0);
        repeat (3) begin
          @(negedge clk); #1;
          chk(pw_en == 0, "R8 empty commit writes nothing", pw_en, 0);
        end
      end else begin
        chk(busy == 1, "R3 busy after commit", busy, 1);
        core_ram_free = 1'b1;
        repeat (3) begin
          @(negedge clk); #1;
          chk(busy == 1 && pw_en == 0, "R4 waits for frame tick", pw_en, 0);
        end
        core_ram_free = 1'b0;
        tick();
        run_copy(n, ROWS[r][7:0]);
      end
    end

    // R9: load offered while busy is refused; R7 afterwards
    put(0, 10'h011, 28'h0ABCDEF);
    commit();
    @(negedge clk);
    ld_valid = 1'b1; ld_slot = 3'd1; ld_addr = 10'h022; ld_data = 28'h7654321;
    #1;
    chk(ld_ready == 0, "R9 ready low while busy", ld_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    ea[0] = 10'h011; ed[0] = 28'h0ABCDEF;
    tick();
    run_copy(1, 8'hFF);
    commit();
    chk(busy == 0, "R7 R9 slots empty after commit", busy, 0);

    // R10: load and commit in the same cycle
    @(negedge clk);
    ld_valid = 1'b1; ld_slot = 3'd2; ld_addr = 10'h2A5; ld_data = 28'h8000001;
    commit_req = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; commit_req = 1'b0;
    #1;
    chk(busy == 1, "R10 same-cycle commit armed", busy, 1);
    ea[0] = 10'h2A5; ed[0] = 28'h8000001;
    tick();
    run_copy(1, 8'hFF);

    // R11: rewrite of a slot keeps last value
    put(3, 10'h100, 28'h1111111);
    put(3, 10'h200, 28'hFFFFFFF);
    commit();
    ea[0] = 10'h200; ed[0] = 28'hFFFFFFF;
    tick();
    run_copy(1, 8'hFF);

    // R12: extra commit while busy ignored
    put(4, 10'h3C3, 28'h0800000);
    put(1, 10'h001, 28'h0000001);
    commit();
    @(negedge clk);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    ea[0] = 10'h001; ed[0] = 28'h0000001;
    ea[1] = 10'h3C3; ed[1] = 28'h0800000;
    tick();
    run_copy(2, 8'b01101101);
    repeat (2) @(negedge clk);
    #1;
    chk(busy == 0, "R12 no re-arm after extra commit", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule